// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block produces the raster timing for a display: horizontal and vertical sync, blanking, a display-enable flag, a start-of-frame pulse, and the current pixel and line coordinates. It also has a second sync pair for a flat panel, with positions of its own, and a flat-panel data-enable. Two counters run on the pixel clock. The horizontal counter steps once per pixel. The vertical counter steps once per line.

All timing is held in 32-bit registers behind a simple word-addressed write/read port. Each timing register packs two positions, and each position is stored as its value minus one. Software must first write a fixed key to the key register. Only then are configuration writes accepted, and writing zero to the key register shuts them out again. A control register gates each part of the output: the generator itself, blanking, each CRT sync and the flat-panel group.

Register map (word addresses on `reg_addr`): 0 key/lock, 1 control, 2 horizontal active/total, 3 horizontal blank, 4 horizontal sync, 5 vertical active/total, 6 vertical blank, 7 vertical sync, 8 flat-panel horizontal sync, 9 flat-panel vertical sync.

Top module: `raster_timing`

## Requirements
- R1: Every write to address 0 is accepted. A read of address 0 returns the lock state in bit 0 (1 = unlocked, 0 = locked). A read of addresses 1 to 9 returns the stored register value, and a read of any other address returns zero.
- R2: While locked, writes to addresses 1 to 9 are ignored. Writing `UNLOCK_KEY` to address 0 unlocks. Writing zero to address 0 locks. Writing any other value to address 0 leaves the lock state unchanged.
- R3: A timing register holds its first position in bits 15:0 and its second in bits 31:16. Each is stored as the position minus one: active/total, blank start/end and sync start/end.
- R4: With the generator enabled, `pix_x` increments every cycle and returns to 0 in the cycle after it equals the total field of address 2. `line_y` advances on each such wrap, and it returns to 0 when it wraps while equal to the total field of address 5.
- R5: The control register has these bits: bit 0 generator, bit 1 blank enable, bit 2 hsync enable, bit 3 vsync enable, bit 4 flat-panel enable. While bit 0 is clear, the counters hold their values and every timing output is low.
- R6: `hsync` is high when bit 2 is set and `pix_x` lies strictly above the start field of address 4 and at or below its end field. `vsync` is high when bit 3 is set and `line_y` meets the same test against address 7.
- R7: With the generator on, `blank` is high when bit 1 is clear. It is also high when `pix_x` lies in the window above start and at or below end of address 3, or when `line_y` lies in that window of address 6.
- R8: `de` is high when the generator and bit 1 are set, `pix_x` is at or below the active field of address 2, and `line_y` is at or below the active field of address 5.
- R9: With bit 4 set, `fp_hsync` follows the window of address 8 on `pix_x`, `fp_vsync` follows the window of address 9 on `line_y`, and `fp_de` equals `de`. With bit 4 clear, all three are low.
- R10: `sof` is high exactly when the generator is on and both counters are zero.
- R11: A synchronous reset clears every register and both counters and locks the port, which leaves all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from address) |
| hsync | output | 1 | CRT horizontal sync, active high |
| vsync | output | 1 | CRT vertical sync, active high |
| blank | output | 1 | Blanking, active high |
| de | output | 1 | Active video flag |
| fp_hsync | output | 1 | Flat-panel horizontal sync |
| fp_vsync | output | 1 | Flat-panel vertical sync |
| fp_de | output | 1 | Flat-panel data enable |
| sof | output | 1 | Start-of-frame flag |
| pix_x | output | CW | Current pixel count |
| line_y | output | CW | Current line count |

## Verification
The assertions watch the counter discipline on every cycle: a step of one or a wrap at the programmed total, a line held within a row, and frozen counters while disabled. They also check that every output stays quiet with the generator off, that the locked port leaves its registers unchanged, that the frame flag and display-enable stay inside the legal coordinate range, and that reset clears the block. The exact shape of each output depends on the programmed register contents: where each sync and blank window falls, the one-line lead of the flat-panel vertical pulse, forced blanking, and the resumption of the count after a pause. Only the bench's directed scenarios show these, by comparing every cycle of several frames against a model.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int          CW         = 16,
  parameter logic [31:0] UNLOCK_KEY = 32'h5EC0_0DE5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [3:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          de,
  output logic          fp_hsync,
  output logic          fp_vsync,
  output logic          fp_de,
  output logic          sof,
  output logic [CW-1:0] pix_x,
  output logic [CW-1:0] line_y
);
  // CW must not exceed 16: each field occupies one half-word.
  localparam int NTIM = 8;
  localparam int TIW  = $clog2(NTIM);
  localparam logic [3:0] TBASE = 4'd2;

  logic            unlocked;
  logic [4:0]      ctrl;
  logic [31:0]     tim [NTIM];
  logic [3:0]      toff;
  logic            tsel;

  assign toff = reg_addr - TBASE;
  assign tsel = (reg_addr >= TBASE) && (reg_addr < TBASE + 4'(NTIM));

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
      ctrl     <= '0;
      for (int i = 0; i < NTIM; i++) tim[i] <= '0;
    end else if (reg_we) begin
      if (reg_addr == 4'd0) begin
        if (reg_wdata == UNLOCK_KEY) unlocked <= 1'b1;
        else if (reg_wdata == 32'd0) unlocked <= 1'b0;
      end else if (unlocked) begin
        if (reg_addr == 4'd1) ctrl <= reg_wdata[4:0];
        else if (tsel) tim[toff[TIW-1:0]] <= reg_wdata;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == 4'd0) reg_rdata = {31'd0, unlocked};
    else if (reg_addr == 4'd1) reg_rdata = {27'd0, ctrl};
    else if (tsel) reg_rdata = tim[toff[TIW-1:0]];
  end

  logic gen, blank_en, hs_en, vs_en, fp_en;
  assign {fp_en, vs_en, hs_en, blank_en, gen} = ctrl;

  logic [CW-1:0] h_act_f, h_tot_f, v_act_f, v_tot_f;
  assign h_act_f = tim[0][CW-1:0];
  assign h_tot_f = tim[0][16 +: CW];
  assign v_act_f = tim[3][CW-1:0];
  assign v_tot_f = tim[3][16 +: CW];

  function automatic logic in_win(input logic [CW-1:0] c, input logic [31:0] w);
    return (c > w[CW-1:0]) && (c <= w[16 +: CW]);
  endfunction

  logic h_end, v_end;
  assign h_end = (pix_x == h_tot_f);
  assign v_end = (line_y == v_tot_f);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_x  <= '0;
      line_y <= '0;
    end else if (gen) begin
      if (h_end) begin
        pix_x  <= '0;
        line_y <= v_end ? '0 : line_y + 1'b1;
      end else begin
        pix_x <= pix_x + 1'b1;
      end
    end
  end

  logic vis;
  assign vis      = (pix_x <= h_act_f) && (line_y <= v_act_f);
  assign de       = gen && blank_en && vis;
  assign blank    = gen && (!blank_en || in_win(pix_x, tim[1]) || in_win(line_y, tim[4]));
  assign hsync    = gen && hs_en && in_win(pix_x, tim[2]);
  assign vsync    = gen && vs_en && in_win(line_y, tim[5]);
  assign fp_hsync = gen && fp_en && in_win(pix_x, tim[6]);
  assign fp_vsync = gen && fp_en && in_win(line_y, tim[7]);
  assign fp_de    = fp_en && de;
  assign sof      = gen && (pix_x == '0) && (line_y == '0);
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          gen,
  input logic          unlocked,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [CW-1:0] h_act_f,
  input logic [CW-1:0] h_tot_f,
  input logic [CW-1:0] v_act_f,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] line_y,
  input logic          hsync,
  input logic          vsync,
  input logic          blank,
  input logic          de,
  input logic          fp_hsync,
  input logic          fp_vsync,
  input logic          fp_de,
  input logic          sof
);
  p_hwrap_r4: assert property (@(posedge clk) disable iff (rst)
    gen && (pix_x == h_tot_f) |=> pix_x == '0);

  p_hstep_r4: assert property (@(posedge clk) disable iff (rst)
    gen && (pix_x != h_tot_f) |=> pix_x == $past(pix_x) + 1'b1);

  p_line_hold_r4: assert property (@(posedge clk) disable iff (rst)
    gen && (pix_x != h_tot_f) |=> $stable(line_y));

  p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    !gen |=> $stable(pix_x) && $stable(line_y));

  p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !gen |-> !(hsync || vsync || blank || de || fp_hsync || fp_vsync || fp_de || sof));

  p_locked_r2: assert property (@(posedge clk) disable iff (rst)
    !unlocked && reg_we && (reg_addr != 4'd0) |=>
      $stable(gen) && $stable(h_act_f) && $stable(h_tot_f) && $stable(v_act_f));

  p_sof_r10: assert property (@(posedge clk) disable iff (rst)
    sof |-> (pix_x == '0) && (line_y == '0));

  p_de_r8: assert property (@(posedge clk) disable iff (rst)
    de |-> (pix_x <= h_act_f) && (line_y <= v_act_f));

  p_fpde_r9: assert property (@(posedge clk) disable iff (rst)
    fp_de |-> de);

  p_reset_r11: assert property (@(posedge clk)
    rst |=> !unlocked && !gen && (pix_x == '0) && (line_y == '0));
endmodule

bind raster_timing raster_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .gen(gen), .unlocked(unlocked),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .h_act_f(h_act_f), .h_tot_f(h_tot_f), .v_act_f(v_act_f),
  .pix_x(pix_x), .line_y(line_y),
  .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
  .fp_hsync(fp_hsync), .fp_vsync(fp_vsync), .fp_de(fp_de), .sof(sof)
);

// File: tb/raster_timing_tb_top.sv
`timescale 1ns/1ps
module raster_timing_tb_top;
  localparam int CW = 16;
  localparam logic [31:0] KEY = 32'h5EC0_0DE5;

  logic clk = 1'b0;
  logic rst;
  logic reg_we;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic hsync, vsync, blank, de, fp_hsync, fp_vsync, fp_de, sof;
  logic [CW-1:0] pix_x, line_y;

  always #10 clk = ~clk;

  raster_timing #(.CW(CW), .UNLOCK_KEY(KEY)) dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .blank(blank), .de(de),
    .fp_hsync(fp_hsync), .fp_vsync(fp_vsync), .fp_de(fp_de), .sof(sof),
    .pix_x(pix_x), .line_y(line_y)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [31:0] m_tim [8];
  logic [4:0]  m_ctrl;
  logic        m_unl;
  logic [15:0] m_h, m_v;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic win(logic [15:0] c, logic [31:0] w);
    return (c > w[15:0]) && (c <= w[31:16]);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) m_tim[i] = '0;
    m_ctrl = '0; m_unl = 1'b0; m_h = '0; m_v = '0;
  endtask

  task automatic model_edge(bit w, logic [3:0] a, logic [31:0] d);
    if (m_ctrl[0]) begin
      if (m_h == m_tim[0][31:16]) begin
        m_h = '0;
        m_v = (m_v == m_tim[3][31:16]) ? 16'd0 : m_v + 16'd1;
      end else m_h = m_h + 16'd1;
    end
    if (w) begin
      if (a == 4'd0) begin
        if (d == KEY) m_unl = 1'b1;
        else if (d == 32'd0) m_unl = 1'b0;
      end else if (m_unl) begin
        if (a == 4'd1) m_ctrl = d[4:0];
        else if (a >= 4'd2 && a <= 4'd9) m_tim[a - 4'd2] = d;
      end
    end
  endtask

  task automatic cyc(bit w, logic [3:0] a, logic [31:0] d);
    reg_we = w; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    model_edge(w, a, d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string req);
    reg_addr = a;
    #1;
    chk(req, $sformatf("rdata@%0d", a), reg_rdata, exp);
  endtask

  task automatic check_outs();
    logic g, d_e;
    g   = m_ctrl[0];
    d_e = g && m_ctrl[1] && (m_h <= m_tim[0][15:0]) && (m_v <= m_tim[3][15:0]);
    chk("R4", "pix_x", 32'(pix_x), 32'(m_h));
    chk("R4", "line_y", 32'(line_y), 32'(m_v));
    chk("R6", "hsync", 32'(hsync), 32'(g && m_ctrl[2] && win(m_h, m_tim[2])));
    chk("R6", "vsync", 32'(vsync), 32'(g && m_ctrl[3] && win(m_v, m_tim[5])));
    chk("R7", "blank", 32'(blank),
        32'(g && (!m_ctrl[1] || win(m_h, m_tim[1]) || win(m_v, m_tim[4]))));
    chk("R8", "de", 32'(de), 32'(d_e));
    chk("R9", "fp_hsync", 32'(fp_hsync), 32'(g && m_ctrl[4] && win(m_h, m_tim[6])));
    chk("R9", "fp_vsync", 32'(fp_vsync), 32'(g && m_ctrl[4] && win(m_v, m_tim[7])));
    chk("R9", "fp_de", 32'(fp_de), 32'(m_ctrl[4] && d_e));
    chk("R10", "sof", 32'(sof), 32'(g && m_h == 16'd0 && m_v == 16'd0));
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 4'd0, 32'd0);
      check_outs();
    end
  endtask

  task automatic t_reset_state();
    check_outs();
    for (int a = 0; a < 10; a++) rd(4'(a), 32'd0, "R11");
  endtask

  task automatic t_lock();
    cyc(1'b1, 4'd2, 32'h0009_0003);
    rd(4'd2, 32'd0, "R2");
    cyc(1'b1, 4'd0, 32'h0000_1234);
    rd(4'd0, 32'd0, "R2");
    cyc(1'b1, 4'd1, 32'h1F);
    rd(4'd1, 32'd0, "R2");
    cyc(1'b1, 4'd0, KEY);
    rd(4'd0, 32'd1, "R1");
    cyc(1'b1, 4'd2, 32'h0009_0003);
    rd(4'd2, 32'h0009_0003, "R1");
    cyc(1'b1, 4'd0, 32'h77);
    rd(4'd0, 32'd1, "R2");
    cyc(1'b1, 4'd0, 32'd0);
    rd(4'd0, 32'd0, "R2");
    cyc(1'b1, 4'd2, 32'hFFFF_FFFF);
    rd(4'd2, 32'h0009_0003, "R2");
    rd(4'd12, 32'd0, "R1");
  endtask

  // R3: 10-pixel lines (4 active), 6-line frames (3 active), fields minus one
  task automatic t_frame();
    cyc(1'b1, 4'd0, KEY);
    cyc(1'b1, 4'd2, 32'h0009_0003);
    cyc(1'b1, 4'd3, 32'h0009_0003);
    cyc(1'b1, 4'd4, 32'h0007_0005);
    cyc(1'b1, 4'd5, 32'h0005_0002);
    cyc(1'b1, 4'd6, 32'h0005_0002);
    cyc(1'b1, 4'd7, 32'h0004_0003);
    cyc(1'b1, 4'd8, 32'h0007_0005);
    cyc(1'b1, 4'd9, 32'h0003_0002);
    rd(4'd4, 32'h0007_0005, "R3");
    rd(4'd9, 32'h0003_0002, "R3");
    cyc(1'b1, 4'd1, 32'h1F);
    check_outs();
    chk("R10", "sof at enable", 32'(sof), 32'd1);
    run(130);
  endtask

  task automatic t_pause();
    cyc(1'b1, 4'd1, 32'h1E);
    check_outs();
    run(15);
    cyc(1'b1, 4'd1, 32'h1F);
    check_outs();
    run(25);
  endtask

  task automatic t_force_blank();
    cyc(1'b1, 4'd1, 32'h1D);
    check_outs();
    run(30);
  endtask

  task automatic t_sync_off();
    cyc(1'b1, 4'd1, 32'h03);
    check_outs();
    run(70);
  endtask

  task automatic t_mid_reset();
    rst = 1'b1;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
    check_outs();
    rd(4'd0, 32'd0, "R11");
    rd(4'd1, 32'd0, "R11");
    rd(4'd5, 32'd0, "R11");
    run(3);
  endtask

  initial begin
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_lock();
    t_frame();
    t_pause();
    t_force_blank();
    t_sync_off();
    t_mid_reset();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule